// File: doc/BRIEF.md
# Doorbell Mailbox Register Unit

This block is a doorbell mailbox between two processors. One side, the sender, and the other side, the receiver, each reach it through their own small register bus. Each bus has an address, write data, a write strobe, a read strobe and read data. Between the two frames sits a parameterised, even number of 32-bit flag words, one per channel. The sender raises flag bits in a channel. The receiver sees the same word in its own frame, takes an interrupt while the word is nonzero, and acknowledges by clearing the bits it has handled. The sender treats a message as delivered once the channel's status reads back as zero.

Each channel owns a 0x20-byte window at n*0x20 in both frames. Inside that window the status word is at 0x0, the clear port is at 0x8 and the set port is at 0xC. The upper part of the frame holds several shared registers. A channel-count word and an identification word appear in both frames. The sender frame also has an access request with a matching ready flag. The receiver frame has an interrupt-enable word whose bit 2 gates a combined interrupt. Read data is registered: it appears in the cycle after the read strobe.

Top module: `dbell_mailbox`

## Requirements
- R1: A write to a channel's set port (offset 0xC) ORs the write data into that channel's status word. From the next cycle the new word is returned by status reads (offset 0x0) in both the sender and receiver frames.
- R2: A write to a channel's clear port (offset 0x8) from either frame clears the status bits that are 1 in the write data. Reads of the set and clear ports return zero.
- R3: When a set and a clear reach the same bit of the same channel in the same cycle, the bit ends up set.
- R4: Channel n's registers start at n*0x20. A write lands only on the channel it addresses, and addresses at or beyond NUM_CH*0x20 that are below 0xF80 read zero.
- R5: The word at 0xF80 reads NUM_CH in both frames. NUM_CH must be nonzero and even.
- R6: In the sender frame, bit 0 of 0xF88 is the access request, written and read back. The ready flag at 0xF8C (bit 0) goes high one cycle after the request is registered. It goes low in the same cycle the release is registered.
- R7: rcv_ch_irq[n] is high in the cycle after channel n's status is nonzero, and low in the cycle after it is zero.
- R8: With MINOR_REV equal to 1, rcv_irq is high in the cycle after some channel status is nonzero while bit 2 of the receiver's 0xF98 word is set. Only bit 2 of that word is stored. For any other MINOR_REV, rcv_irq follows any nonzero status regardless of the enable.
- R9: The word at 0xFCC reads MINOR_REV in bits [3:0] and MAJOR_REV in bits [7:4], with all other bits zero, in both frames.
- R10: After reset all status words, the access request and ready, the interrupt enable, both interrupt outputs and both read data buses are zero.
- R11: Writes to read-only or foreign registers have no effect. This covers status words, 0xF80, 0xF8C, 0xFCC, 0xF88 from the receiver and 0xF98 from the sender. Read data is zero in any cycle after no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_addr | input | 12 | Sender frame byte address |
| snd_wdata | input | 32 | Sender write data |
| snd_we | input | 1 | Sender write strobe |
| snd_re | input | 1 | Sender read strobe |
| snd_rdata | output | 32 | Sender read data, valid the cycle after snd_re |
| rcv_addr | input | 12 | Receiver frame byte address |
| rcv_wdata | input | 32 | Receiver write data |
| rcv_we | input | 1 | Receiver write strobe |
| rcv_re | input | 1 | Receiver read strobe |
| rcv_rdata | output | 32 | Receiver read data, valid the cycle after rcv_re |
| rcv_ch_irq | output | NUM_CH | Per-channel interrupt, high while that status is nonzero |
| rcv_irq | output | 1 | Combined receiver interrupt |

## Verification
The bench drives a set from the sender and a clear from the receiver onto overlapping bits of one channel in the same cycle. A design that lets clear win loses the doorbell. It checks that a write to channel 3 leaves channel 1 untouched and that a status write is ignored. An off-by-one in the window decode or a writable status word would corrupt a neighbour. It reads the ready flag immediately after the request and again a cycle later, which catches a ready that is combinational or two cycles late. It toggles the combined-interrupt enable while a flag is pending, and writes the enable from the wrong frame, to expose missing gating or a frame mix-up.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
    localparam int unsigned ADDR_W    = 12;
    localparam int unsigned WIN_LG    = 5;       // 0x20-byte channel window
    localparam logic [4:0]  OFS_STAT  = 5'h00;
    localparam logic [4:0]  OFS_CLR   = 5'h08;
    localparam logic [4:0]  OFS_SET   = 5'h0C;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 12'hF80;
    localparam logic [ADDR_W-1:0] ADR_REQ   = 12'hF88;
    localparam logic [ADDR_W-1:0] ADR_RDY   = 12'hF8C;
    localparam logic [ADDR_W-1:0] ADR_INTEN = 12'hF98;
    localparam logic [ADDR_W-1:0] ADR_ID    = 12'hFCC;
    localparam int unsigned COMB_BIT  = 2;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_STAT,
        RK_COUNT,
        RK_REQ,
        RK_RDY,
        RK_INTEN,
        RK_ID
    } rd_kind_e;
endpackage

// File: rtl/dbell_frame_dec.sv
module dbell_frame_dec
    import dbell_pkg::*;
#(
    parameter int unsigned NUM_CH    = 4,
    parameter bit          IS_SENDER = 1'b1,
    parameter int unsigned CW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    output logic [NUM_CH-1:0] set_hit,
    output logic [NUM_CH-1:0] clr_hit,
    output logic [CW-1:0]     ch_idx,
    output rd_kind_e          rd_kind,
    output logic              cfg_wr
);
    localparam int unsigned WIN_END = NUM_CH << WIN_LG;
    localparam int unsigned HI_W    = ADDR_W - WIN_LG;
    localparam logic [ADDR_W-1:0] CFG_ADR = IS_SENDER ? ADR_REQ : ADR_INTEN;

    logic       in_win;
    logic [4:0] sub;

    assign in_win = ({{(32-ADDR_W){1'b0}}, addr} < 32'(WIN_END));
    assign sub    = addr[WIN_LG-1:0];
    assign ch_idx = addr[CW+WIN_LG-1:WIN_LG];
    assign cfg_wr = we && (addr == CFG_ADR);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
        assign set_hit[g] = we && in_win && (addr[ADDR_W-1:WIN_LG] == HI_W'(g)) && (sub == OFS_SET);
        assign clr_hit[g] = we && in_win && (addr[ADDR_W-1:WIN_LG] == HI_W'(g)) && (sub == OFS_CLR);
    end

    always_comb begin
        rd_kind = RK_NONE;
        if (re) begin
            if (in_win) begin
                if (sub == OFS_STAT) rd_kind = RK_STAT;
            end else begin
                unique case (addr)
                    ADR_COUNT: rd_kind = RK_COUNT;
                    ADR_REQ:   rd_kind = IS_SENDER ? RK_REQ : RK_NONE;
                    ADR_RDY:   rd_kind = IS_SENDER ? RK_RDY : RK_NONE;
                    ADR_INTEN: rd_kind = IS_SENDER ? RK_NONE : RK_INTEN;
                    ADR_ID:    rd_kind = RK_ID;
                    default:   rd_kind = RK_NONE;
                endcase
            end
        end
    end

    // R4: one write reaches at most one channel port
    p_single_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_hit, clr_hit}));
endmodule

// File: rtl/dbell_flag_bank.sv
module dbell_flag_bank #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DW     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          s_set_hit,
    input  logic [NUM_CH-1:0]          s_clr_hit,
    input  logic [DW-1:0]              s_wdata,
    input  logic [NUM_CH-1:0]          r_set_hit,
    input  logic [NUM_CH-1:0]          r_clr_hit,
    input  logic [DW-1:0]              r_wdata,
    output logic [NUM_CH-1:0][DW-1:0]  flags_q,
    output logic [NUM_CH-1:0]          ch_irq_q
);
    typedef struct packed {
        logic [NUM_CH-1:0][DW-1:0] flags;
        logic [NUM_CH-1:0]         ch_irq;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            logic [DW-1:0] setm, clrm;
            setm = (s_set_hit[i] ? s_wdata : '0) | (r_set_hit[i] ? r_wdata : '0);
            clrm = (s_clr_hit[i] ? s_wdata : '0) | (r_clr_hit[i] ? r_wdata : '0);
            // set is applied after clear so it wins on a shared bit
            st_d.flags[i]  = (st_q.flags[i] & ~clrm) | setm;
            st_d.ch_irq[i] = |st_q.flags[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q  = st_q.flags;
    assign ch_irq_q = st_q.ch_irq;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R1 and R3: set bits are present next cycle, even against a clear
        p_set_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
            s_set_hit[g] |=> ((flags_q[g] & $past(s_wdata)) == $past(s_wdata)));
        // R2: cleared bits are gone when no set touched the channel
        p_clr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (r_clr_hit[g] && !s_set_hit[g] && !r_set_hit[g]) |=> ((flags_q[g] & $past(r_wdata)) == '0));
        // R7: channel interrupt only after a nonzero status
        p_chirq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ch_irq_q[g] |-> $past(flags_q[g] != '0));
    end
endmodule

// File: rtl/dbell_access.sv
module dbell_access (
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr,
    input  logic req_bit,
    output logic req_q,
    output logic rdy_q
);
    typedef struct packed {
        logic req;
        logic rdy;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        if (req_wr) st_d.req = req_bit;
        // ready trails the request by one cycle, drops with the release
        st_d.rdy = st_q.req && st_d.req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_q = st_q.req;
    assign rdy_q = st_q.rdy;

    // R6: ready rises only after a request held for a cycle
    p_rdy_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_q) |-> ($past(req_q) && req_q));
    // R6: no ready without a request
    p_rdy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_q |-> !rdy_q);
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
    import dbell_pkg::*;
#(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned DW        = 32,
    parameter int unsigned MINOR_REV = 1,
    parameter int unsigned MAJOR_REV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       snd_addr,
    input  logic [DW-1:0]     snd_wdata,
    input  logic              snd_we,
    input  logic              snd_re,
    output logic [DW-1:0]     snd_rdata,
    input  logic [11:0]       rcv_addr,
    input  logic [DW-1:0]     rcv_wdata,
    input  logic              rcv_we,
    input  logic              rcv_re,
    output logic [DW-1:0]     rcv_rdata,
    output logic [NUM_CH-1:0] rcv_ch_irq,
    output logic              rcv_irq
);
    localparam int unsigned CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [DW-1:0] ID_WORD  = DW'({4'(MAJOR_REV), 4'(MINOR_REV)});
    localparam logic [DW-1:0] CNT_WORD = DW'(NUM_CH);
    localparam bit GATED = (MINOR_REV == 1);

    if (NUM_CH == 0 || (NUM_CH % 2) != 0) begin : g_bad_count
        $error("dbell_mailbox: NUM_CH must be nonzero and even");
    end

    logic [NUM_CH-1:0] s_set, s_clr, r_set, r_clr;
    logic [CW-1:0]     s_idx, r_idx;
    rd_kind_e          s_kind, r_kind;
    logic              s_cfg_wr, r_cfg_wr;
    logic [NUM_CH-1:0][DW-1:0] flags;
    logic              req, rdy;

    dbell_frame_dec #(.NUM_CH(NUM_CH), .IS_SENDER(1'b1), .CW(CW)) i_snd_dec (
        .clk(clk), .rst_n(rst_n), .addr(snd_addr), .we(snd_we), .re(snd_re),
        .set_hit(s_set), .clr_hit(s_clr), .ch_idx(s_idx), .rd_kind(s_kind), .cfg_wr(s_cfg_wr)
    );

    dbell_frame_dec #(.NUM_CH(NUM_CH), .IS_SENDER(1'b0), .CW(CW)) i_rcv_dec (
        .clk(clk), .rst_n(rst_n), .addr(rcv_addr), .we(rcv_we), .re(rcv_re),
        .set_hit(r_set), .clr_hit(r_clr), .ch_idx(r_idx), .rd_kind(r_kind), .cfg_wr(r_cfg_wr)
    );

    dbell_flag_bank #(.NUM_CH(NUM_CH), .DW(DW)) i_bank (
        .clk(clk), .rst_n(rst_n),
        .s_set_hit(s_set), .s_clr_hit(s_clr), .s_wdata(snd_wdata),
        .r_set_hit(r_set), .r_clr_hit(r_clr), .r_wdata(rcv_wdata),
        .flags_q(flags), .ch_irq_q(rcv_ch_irq)
    );

    dbell_access i_access (
        .clk(clk), .rst_n(rst_n), .req_wr(s_cfg_wr), .req_bit(snd_wdata[0]),
        .req_q(req), .rdy_q(rdy)
    );

    typedef struct packed {
        logic [DW-1:0] s_rd;
        logic [DW-1:0] r_rd;
        logic          comb_en;
        logic          irq;
    } top_t;

    top_t st_d, st_q;

    function automatic logic [DW-1:0] rd_mux(input rd_kind_e k, input logic [CW-1:0] idx,
                                             input logic en_bit);
        logic [DW-1:0] v;
        v = '0;
        unique case (k)
            RK_STAT:  v = flags[idx];
            RK_COUNT: v = CNT_WORD;
            RK_REQ:   v = DW'(req);
            RK_RDY:   v = DW'(rdy);
            RK_INTEN: v = DW'(en_bit) << COMB_BIT;
            RK_ID:    v = ID_WORD;
            default:  v = '0;
        endcase
        return v;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.s_rd = rd_mux(s_kind, s_idx, st_q.comb_en);
        st_d.r_rd = rd_mux(r_kind, r_idx, st_q.comb_en);
        if (r_cfg_wr) st_d.comb_en = rcv_wdata[COMB_BIT];
        st_d.irq  = (|flags) && (GATED ? st_q.comb_en : 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snd_rdata = st_q.s_rd;
    assign rcv_rdata = st_q.r_rd;
    assign rcv_irq   = st_q.irq;

    // R8: the combined interrupt needs a pending flag one cycle earlier
    p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_irq |-> $past(|flags));
    // R11: read data idles at zero
    p_snd_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(snd_re) |-> (snd_rdata == '0));
    p_rcv_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rcv_re) |-> (rcv_rdata == '0));
endmodule

// File: tb/test_dbell_mailbox.sv
module test_dbell_mailbox;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] snd_addr = '0, rcv_addr = '0;
    logic [31:0] snd_wdata = '0, rcv_wdata = '0;
    logic        snd_we = 1'b0, snd_re = 1'b0, rcv_we = 1'b0, rcv_re = 1'b0;
    logic [31:0] snd_rdata, rcv_rdata;
    logic [NCH-1:0] rcv_ch_irq;
    logic        rcv_irq;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;   // 125 MHz

    dbell_mailbox #(.NUM_CH(NCH), .DW(32), .MINOR_REV(1), .MAJOR_REV(1)) i_dbell_mailbox (
        .clk(clk), .rst_n(rst_n),
        .snd_addr(snd_addr), .snd_wdata(snd_wdata), .snd_we(snd_we), .snd_re(snd_re),
        .snd_rdata(snd_rdata),
        .rcv_addr(rcv_addr), .rcv_wdata(rcv_wdata), .rcv_we(rcv_we), .rcv_re(rcv_re),
        .rcv_rdata(rcv_rdata), .rcv_ch_irq(rcv_ch_irq), .rcv_irq(rcv_irq)
    );

    // side: 0 sender, 1 receiver; wr: 1 write, 0 read and compare
    typedef struct packed {
        logic        side;
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 12'h00C, 32'h0000_00F0, 32'h0, 4'd1},          // R1 set ch0
        '{1'b1, 1'b0, 12'h000, 32'h0, 32'h0000_00F0, 4'd1},          // R1 receiver view
        '{1'b0, 1'b0, 12'h000, 32'h0, 32'h0000_00F0, 4'd1},          // R1 sender view
        '{1'b1, 1'b1, 12'h008, 32'h0000_0030, 32'h0, 4'd2},          // R2 clear
        '{1'b0, 1'b0, 12'h000, 32'h0, 32'h0000_00C0, 4'd2},          // R2
        '{1'b1, 1'b0, 12'h008, 32'h0, 32'h0, 4'd2},                  // R2 clear reads 0
        '{1'b0, 1'b0, 12'h00C, 32'h0, 32'h0, 4'd2},                  // R2 set reads 0
        '{1'b0, 1'b1, 12'h06C, 32'hA500_0000, 32'h0, 4'd4},          // R4 set ch3
        '{1'b1, 1'b0, 12'h060, 32'h0, 32'hA500_0000, 4'd4},          // R4
        '{1'b1, 1'b0, 12'h020, 32'h0, 32'h0, 4'd4},                  // R4 ch1 untouched
        '{1'b0, 1'b1, 12'h000, 32'h0000_FFFF, 32'h0, 4'd11},         // R11 status write
        '{1'b0, 1'b0, 12'h000, 32'h0, 32'h0000_00C0, 4'd11},         // R11
        '{1'b0, 1'b0, 12'hF80, 32'h0, 32'd4, 4'd5},                  // R5
        '{1'b1, 1'b0, 12'hF80, 32'h0, 32'd4, 4'd5},                  // R5
        '{1'b1, 1'b0, 12'hFCC, 32'h0, 32'h11, 4'd9},                 // R9
        '{1'b0, 1'b0, 12'h080, 32'h0, 32'h0, 4'd4},                  // R4 past channels
        '{1'b1, 1'b1, 12'h008, 32'h0000_00C0, 32'h0, 4'd2},          // R2
        '{1'b1, 1'b1, 12'h068, 32'hFFFF_FFFF, 32'h0, 4'd2},          // R2
        '{1'b1, 1'b0, 12'h000, 32'h0, 32'h0, 4'd2},                  // R2
        '{1'b1, 1'b0, 12'h060, 32'h0, 32'h0, 4'd2}                   // R2
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // tasks start and end at a falling edge
    task automatic do_wr(input logic side, input logic [11:0] a, input logic [31:0] d);
        if (side) begin rcv_addr = a; rcv_wdata = d; rcv_we = 1'b1; end
        else      begin snd_addr = a; snd_wdata = d; snd_we = 1'b1; end
        @(negedge clk);
        rcv_we = 1'b0; snd_we = 1'b0;
    endtask

    task automatic do_rd(input logic side, input logic [11:0] a, output logic [31:0] d);
        if (side) begin rcv_addr = a; rcv_re = 1'b1; end
        else      begin snd_addr = a; snd_re = 1'b1; end
        @(negedge clk);
        d = side ? rcv_rdata : snd_rdata;
        rcv_re = 1'b0; snd_re = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 irq", {31'b0, rcv_irq}, 32'h0);
        chk("R10 ch_irq", 32'(rcv_ch_irq), 32'h0);
        chk("R10 rdata", snd_rdata | rcv_rdata, 32'h0);
        do_rd(1'b0, 12'h000, v); chk("R10 status", v, 32'h0);
        do_rd(1'b0, 12'hF88, v); chk("R10 request", v, 32'h0);
        do_rd(1'b1, 12'hF98, v); chk("R10 inten", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) do_wr(VECS[i].side, VECS[i].addr, VECS[i].data);
            else begin
                do_rd(VECS[i].side, VECS[i].addr, v);
                chk($sformatf("R%0d vector %0d", VECS[i].tag, i), v, VECS[i].exp);
            end
        end

        // R11 receiver cannot request access, sender cannot enable the interrupt
        do_wr(1'b1, 12'hF88, 32'h1);
        do_rd(1'b0, 12'hF88, v); chk("R11 foreign request", v, 32'h0);
        do_wr(1'b0, 12'hF98, 32'h4);
        do_rd(1'b1, 12'hF98, v); chk("R11 foreign inten", v, 32'h0);

        // R6 access handshake
        do_wr(1'b0, 12'hF88, 32'h1);
        do_rd(1'b0, 12'hF8C, v); chk("R6 ready not yet", v, 32'h0);
        do_rd(1'b0, 12'hF8C, v); chk("R6 ready", v, 32'h1);
        do_rd(1'b0, 12'hF88, v); chk("R6 request readback", v, 32'h1);
        do_wr(1'b0, 12'hF88, 32'h0);
        do_rd(1'b0, 12'hF8C, v); chk("R6 ready dropped", v, 32'h0);

        // R7 and R8 interrupts
        do_wr(1'b0, 12'h00C, 32'h1);
        @(negedge clk);
        chk("R7 ch_irq raised", 32'(rcv_ch_irq), 32'h1);
        chk("R8 gated off", {31'b0, rcv_irq}, 32'h0);
        do_wr(1'b1, 12'hF98, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R8 combined on", {31'b0, rcv_irq}, 32'h1);
        do_rd(1'b1, 12'hF98, v); chk("R8 inten bit2 only", v, 32'h4);

        // R3 simultaneous set and clear on ch1
        snd_addr = 12'h02C; snd_wdata = 32'h0000_000F; snd_we = 1'b1;
        rcv_addr = 12'h028; rcv_wdata = 32'h0000_003C; rcv_we = 1'b1;
        @(negedge clk);
        snd_we = 1'b0; rcv_we = 1'b0;
        do_rd(1'b1, 12'h020, v); chk("R3 set wins", v, 32'h0000_000F);

        // R7 drop after clearing everything
        do_wr(1'b1, 12'h008, 32'hFFFF_FFFF);
        do_wr(1'b1, 12'h028, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R7 ch_irq dropped", 32'(rcv_ch_irq), 32'h0);
        chk("R8 combined dropped", {31'b0, rcv_irq}, 32'h0);
        do_rd(1'b0, 12'h020, v); chk("R1 delivered reads zero", v, 32'h0);

        finish_run();
    end
endmodule